// File: doc/BRIEF.md
# Slave-Serial FPGA Configuration Loader

This block takes a configuration image arriving as a byte stream and loads it into a downstream FPGA over a serial link of three outputs and two inputs. The outputs are an active-low reset/program line, a configuration clock and a serial data line. The inputs are the target's active-low clear indicator and its configuration-complete indicator. A single `start` pulse begins a load. The block first throws away any leading header bytes until it sees a run of four consecutive 0xFF bytes. It then pulses the target's program line and follows the clear indicator through its fall and rise. After that it shifts out the sync bytes, the payload and a fixed tail of 0xFF padding. Finally it waits for the target to report completion.

Each waiting phase is bounded by a coarse tick input, nominally one per millisecond. A phase aborts when its condition is still unmet on the fourth tick after the phase began. Each phase reports its own fault code. The result is shown on `done_ok`, on a one-cycle `error` pulse and on a 2-bit `error_code`. Both stay as they are until the next start.

Top module: `slave_serial_loader`

## Requirements
- R1: After reset, tgt_rst_n, tgt_clk and tgt_dat are all 1, busy, s_ready and done_ok are 0, and error_code is 0.
- R2: Stream bytes accepted before the first run of four consecutive 0xFF bytes are dropped and never shifted. A non-0xFF byte restarts the run count.
- R3: tgt_rst_n goes low only after the sync run is found and stays low until tgt_clr_n is seen low. If tgt_clr_n is still high on the fourth tick after tgt_rst_n fell, the load aborts with error_code 1.
- R4: After tgt_rst_n is released high, the block waits for tgt_clr_n to be high. If it is still low on the fourth tick of that wait, the load aborts with error_code 2.
- R5: The bits sampled on rising tgt_clk edges are, in order: four 0xFF bytes, then every payload byte up to and including the one flagged s_last, then eight 0xFF bytes. Each byte goes out most significant bit first, one bit per rising edge.
- R6: Each low phase of tgt_clk lasts exactly HALF_CLKS clock cycles, and each high phase lasts at least HALF_CLKS cycles. tgt_dat changes only in cycles where tgt_clk is low.
- R7: After the last padding bit, the block waits for tgt_up. If tgt_up is seen, done_ok becomes 1 with error_code 0. If tgt_up is still low on the fourth tick, the load aborts with error_code 3.
- R8: An abort gives exactly one error pulse, in the same cycle that busy drops. tgt_rst_n is high at that point. error_code and done_ok keep their values until the next accepted start.
- R9: s_ready is high only while searching for the sync run or while shifting payload bytes. It is never high during the reset handshake, the padding or the final wait.
- R10: A start pulse while busy is ignored. The load in progress keeps its bit sequence and gives one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (used only when idle) |
| ms_tick | input | 1 | One-cycle timebase tick for the timeouts |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Stream byte accepted when high with s_valid |
| tgt_rst_n | output | 1 | Active-low program/reset line to the target |
| tgt_clk | output | 1 | Configuration clock to the target |
| tgt_dat | output | 1 | Serial configuration data to the target |
| tgt_clr_n | input | 1 | Target's active-low clearing indicator |
| tgt_up | input | 1 | Target's configuration-complete indicator |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | Last load completed successfully |
| error | output | 1 | One-cycle abort pulse |
| error_code | output | 2 | 0 none, 1 clear never fell, 2 clear never rose, 3 complete never seen |

## Verification
tgt_rst_n falls in the cycle after the clock edge that accepts the fourth sync byte. Each bit reaches tgt_dat together with a falling tgt_clk, and its rising edge comes HALF_CLKS cycles later. `error`, `done_ok` and `error_code` change one cycle after the edge where the deciding tick or target input is sampled. The bench drives all inputs and samples all outputs on the falling clock edge. It records the rising edges of tgt_clk as they happen and compares them with a bit list it builds itself after the load ends. Timeouts are judged by counting how many cycles tgt_rst_n stayed low against a window built from the tick period, not by predicting a single exact cycle.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef enum logic [1:0] {
    FAULT_NONE      = 2'd0,
    FAULT_CLR_HELD  = 2'd1,
    FAULT_CLR_STUCK = 2'd2,
    FAULT_NO_UP     = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_PROG,
    ST_WAKE,
    ST_LEAD,
    ST_BODY,
    ST_PAD,
    ST_FINISH
  } seq_e;

  function automatic logic is_fill(input logic [7:0] b);
    return b == 8'hFF;
  endfunction

endpackage

// File: rtl/fsl_sync_hunt.sv
module fsl_sync_hunt #(
  parameter int SYNC_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       acc,
  input  logic [7:0] dat,
  output logic       found
);
  import fsl_pkg::*;

  localparam int CW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN + 1) : 1;

  logic [CW-1:0] run;

  assign found = en && acc && is_fill(dat) && (run == CW'(SYNC_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run <= '0;
    else if (!en)               run <= '0;
    else if (acc) begin
      if (!is_fill(dat))        run <= '0;
      else if (found)           run <= '0;
      else                      run <= run + 1'b1;
    end
  end

  // R2: the run counter restarts on a non-fill byte
  a_r2_run_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && acc && !is_fill(dat)) |=> (run == '0));

endmodule

// File: rtl/fsl_tick_window.sv
module fsl_tick_window #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = (LIMIT > 0) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt;

  assign expired = tick && (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (tick && cnt != CW'(LIMIT))  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
  parameter int HALF_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_valid,
  input  logic [7:0] ld_byte,
  output logic       ld_ready,
  output logic       ser_clk,
  output logic       ser_dat
);
  localparam int HW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic          active;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          hi_phase;
  logic [HW-1:0] hcnt;
  logic          clk_q;
  logic          dat_q;
  logic          half_end;

  assign half_end = (hcnt == HW'(HALF_CLKS - 1));
  assign ld_ready = !active;
  assign ser_clk  = clk_q;
  assign ser_dat  = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sh       <= '0;
      bitn     <= '0;
      hi_phase <= 1'b0;
      hcnt     <= '0;
      clk_q    <= 1'b1;
      dat_q    <= 1'b1;
    end else if (!active) begin
      if (ld_valid) begin
        active   <= 1'b1;
        sh       <= ld_byte;
        bitn     <= '0;
        hi_phase <= 1'b0;
        hcnt     <= '0;
        clk_q    <= 1'b0;
        dat_q    <= ld_byte[7];
      end
    end else if (!half_end) begin
      hcnt <= hcnt + 1'b1;
    end else begin
      hcnt <= '0;
      if (!hi_phase) begin
        hi_phase <= 1'b1;
        clk_q    <= 1'b1;
      end else begin
        hi_phase <= 1'b0;
        if (bitn == 3'd7) begin
          active <= 1'b0;
        end else begin
          bitn  <= bitn + 1'b1;
          sh    <= sh << 1;
          dat_q <= sh[6];
          clk_q <= 1'b0;
        end
      end
    end
  end

  // R6: data moves only while the serial clock is low
  a_r6_dat_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dat) |-> !ser_clk);

  // R5: a loaded byte presents its top bit first, with the clock low
  a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (!ser_clk && ser_dat == $past(ld_byte[7])));

endmodule

// File: rtl/slave_serial_loader.sv
module slave_serial_loader #(
  parameter int HALF_CLKS  = 2,
  parameter int TICK_LIMIT = 3,
  parameter int SYNC_LEN   = 4,
  parameter int PAD_BYTES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ms_tick,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tgt_rst_n,
  output logic       tgt_clk,
  output logic       tgt_dat,
  input  logic       tgt_clr_n,
  input  logic       tgt_up,
  output logic       busy,
  output logic       done_ok,
  output logic       error,
  output logic [1:0] error_code
);
  import fsl_pkg::*;

  localparam int FW = $clog2(SYNC_LEN + PAD_BYTES + 1);

  seq_e          st, st_d;
  logic [FW-1:0] fill_cnt;
  logic          fill_inc;
  logic          ld_valid, ld_ready;
  logic [7:0]    ld_byte;
  logic          sync_found;
  logic          win_clr, win_expired;
  logic          abort, succeed;
  fault_e        abort_code;
  fault_e        code_q;
  logic          ok_q, err_q;

  fsl_sync_hunt #(.SYNC_LEN(SYNC_LEN)) u_hunt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st == ST_HUNT),
    .acc   (s_valid && s_ready),
    .dat   (s_data),
    .found (sync_found)
  );

  fsl_tick_window #(.LIMIT(TICK_LIMIT)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (win_clr),
    .tick    (ms_tick),
    .expired (win_expired)
  );

  fsl_shifter #(.HALF_CLKS(HALF_CLKS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_byte  (ld_byte),
    .ld_ready (ld_ready),
    .ser_clk  (tgt_clk),
    .ser_dat  (tgt_dat)
  );

  always_comb begin
    st_d       = st;
    ld_valid   = 1'b0;
    ld_byte    = 8'hFF;
    s_ready    = 1'b0;
    fill_inc   = 1'b0;
    abort      = 1'b0;
    abort_code = FAULT_NONE;
    succeed    = 1'b0;
    case (st)
      ST_IDLE: if (start) st_d = ST_HUNT;
      ST_HUNT: begin
        s_ready = 1'b1;
        if (sync_found) st_d = ST_PROG;
      end
      ST_PROG: begin
        if (!tgt_clr_n) st_d = ST_WAKE;
        else if (win_expired) begin
          abort = 1'b1; abort_code = FAULT_CLR_HELD; st_d = ST_IDLE;
        end
      end
      ST_WAKE: begin
        if (tgt_clr_n) st_d = ST_LEAD;
        else if (win_expired) begin
          abort = 1'b1; abort_code = FAULT_CLR_STUCK; st_d = ST_IDLE;
        end
      end
      ST_LEAD: begin
        ld_valid = 1'b1;
        if (ld_ready) begin
          fill_inc = 1'b1;
          if (fill_cnt == FW'(SYNC_LEN - 1)) st_d = ST_BODY;
        end
      end
      ST_BODY: begin
        ld_valid = s_valid;
        ld_byte  = s_data;
        s_ready  = ld_ready;
        if (s_valid && ld_ready && s_last) st_d = ST_PAD;
      end
      ST_PAD: begin
        if (fill_cnt != FW'(PAD_BYTES)) begin
          ld_valid = 1'b1;
          if (ld_ready) fill_inc = 1'b1;
        end else if (ld_ready) begin
          st_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        if (tgt_up) begin
          succeed = 1'b1; st_d = ST_IDLE;
        end else if (win_expired) begin
          abort = 1'b1; abort_code = FAULT_NO_UP; st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign win_clr = (st_d != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      fill_cnt <= '0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= FAULT_NONE;
    end else begin
      st    <= st_d;
      err_q <= abort;
      if (st_d != st)    fill_cnt <= '0;
      else if (fill_inc) fill_cnt <= fill_cnt + 1'b1;
      if (st == ST_IDLE && start) begin
        ok_q   <= 1'b0;
        code_q <= FAULT_NONE;
      end else if (succeed) begin
        ok_q <= 1'b1;
      end else if (abort) begin
        code_q <= abort_code;
      end
    end
  end

  assign tgt_rst_n  = (st != ST_PROG);
  assign busy       = (st != ST_IDLE);
  assign done_ok    = ok_q;
  assign error      = err_q;
  assign error_code = code_q;

  // R9: the stream is only taken while busy and outside the program pulse
  a_r9_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && tgt_rst_n));

  // R3: the program pulse begins only after the sync run was found
  a_r3_prog_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst_n) |-> $past(sync_found));

  // R8: abort pulse is one cycle wide
  a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);

  // R8: abort lands in idle with the program line released and a code set
  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && tgt_rst_n && error_code != 2'd0));

  // R7: success only follows an observed completion indicator
  a_r7_ok_needs_up: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> $past(tgt_up));

  // R7: success never carries a fault code
  a_r7_ok_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> (error_code == 2'd0));

endmodule

// File: tb/slave_serial_loader_bench.sv
module slave_serial_loader_bench;

  localparam int HALF = 2;
  localparam int TP   = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       ms_tick = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       tgt_rst_n, tgt_clk, tgt_dat;
  logic       tgt_clr_n = 1'b1;
  logic       tgt_up = 1'b0;
  logic       busy, done_ok, error;
  logic [1:0] error_code;

  always #10 clk = ~clk;

  slave_serial_loader #(.HALF_CLKS(HALF), .TICK_LIMIT(3), .SYNC_LEN(4), .PAD_BYTES(8))
  u_slave_serial_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .tgt_rst_n(tgt_rst_n), .tgt_clk(tgt_clk), .tgt_dat(tgt_dat),
    .tgt_clr_n(tgt_clr_n), .tgt_up(tgt_up),
    .busy(busy), .done_ok(done_ok), .error(error), .error_code(error_code)
  );

  int checks = 0;
  int errs   = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_in(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // timebase
  initial begin
    forever begin
      repeat (TP - 1) @(negedge clk);
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  // observers
  logic cap [0:4095];
  int   cap_total = 0;
  int   low_total = 0;
  int   err_total = 0;
  int   last_code = 0;
  int   lo_run = 0;
  int   lo_bad = 0;
  int   dat_bad = 0;
  logic prev_dat = 1'b1;

  always @(posedge tgt_clk) begin
    if (rst_n) begin
      cap[cap_total % 4096] = tgt_dat;
      cap_total++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!tgt_rst_n) low_total++;
      if (error) begin err_total++; last_code = error_code; end
      if (!tgt_clk) lo_run++;
      else begin
        if (lo_run != 0 && lo_run != HALF) lo_bad++;
        lo_run = 0;
      end
      if (tgt_dat != prev_dat && tgt_clk) dat_bad++;
      prev_dat = tgt_dat;
    end
  end

  // load context
  logic [7:0] tx [$];
  logic [7:0] exp_b [$];
  logic       stop;
  int         cap0;
  int         want_bits;

  function automatic logic exp_bit(input int k);
    logic [7:0] b;
    b = exp_b[k / 8];
    return b[7 - (k % 8)];
  endfunction

  task automatic sender();
    for (int i = 0; i < tx.size(); i++) begin
      @(negedge clk);
      s_data  = tx[i];
      s_valid = 1'b1;
      s_last  = (i == tx.size() - 1);
      #1;
      while (!s_ready && !stop) begin
        @(negedge clk);
        #1;
      end
      if (stop) break;
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic target(input int lo_dly, input int hi_dly, input bit up_en);
    while (tgt_rst_n && !stop) @(negedge clk);
    if (stop) return;
    chk("R9 ready low in program pulse", s_ready, 0);
    if (lo_dly < 0) return;
    repeat (lo_dly) @(negedge clk);
    tgt_clr_n = 1'b0;
    while (!tgt_rst_n && !stop) @(negedge clk);
    if (stop) return;
    if (hi_dly < 0) return;
    repeat (hi_dly) @(negedge clk);
    tgt_clr_n = 1'b1;
    if (!up_en) return;
    while ((cap_total - cap0) < want_bits && !stop) @(negedge clk);
    if (!stop) tgt_up = 1'b1;
  endtask

  task automatic do_load(input int hdr_n, input int pay_n, input int lo_dly,
                         input int hi_dly, input bit up_en, input bit dirty,
                         input bit restart);
    int exp_code, low0, err0, got_bits;
    tx.delete();
    exp_b.delete();
    if (dirty) begin
      tx.push_back(8'hFF); tx.push_back(8'hFF); tx.push_back(8'hFF); tx.push_back(8'h00);
      tx.push_back(8'hFF); tx.push_back(8'hFF); tx.push_back(8'h55);
    end
    for (int i = 0; i < hdr_n; i++) tx.push_back(8'($urandom_range(0, 254)));
    for (int i = 0; i < 4; i++) begin tx.push_back(8'hFF); exp_b.push_back(8'hFF); end
    for (int i = 0; i < pay_n; i++) begin
      logic [7:0] b;
      b = 8'($urandom_range(0, 255));
      tx.push_back(b);
      exp_b.push_back(b);
    end
    for (int i = 0; i < 8; i++) exp_b.push_back(8'hFF);
    exp_code = (lo_dly < 0) ? 1 : (hi_dly < 0) ? 2 : (!up_en) ? 3 : 0;
    want_bits = (exp_code == 1 || exp_code == 2) ? 0 : 8 * exp_b.size();
    tgt_clr_n = 1'b1;
    tgt_up    = 1'b0;
    stop      = 1'b0;
    cap0      = cap_total;
    low0      = low_total;
    err0      = err_total;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy after start", busy, 1);
    fork
      sender();
      target(lo_dly, hi_dly, up_en);
      begin
        while (busy) @(negedge clk);
        stop = 1'b1;
      end
      begin
        if (restart) begin
          repeat (300) @(negedge clk);
          chk("R10 still busy at restart", busy, 1);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    repeat (3) @(negedge clk);
    chk("R7/R3/R4 error_code", error_code, exp_code);
    chk("R7 done_ok", done_ok, exp_code == 0);
    chk("R8 error pulses", err_total - err0, exp_code != 0);
    if (exp_code != 0) chk("R8 pulse code", last_code, exp_code);
    chk("R8 program released", tgt_rst_n, 1);
    chk("R9 ready idle", s_ready, 0);
    chk("R10 idle after one result", busy, 0);
    if (exp_code == 1)
      chk_in("R3 program pulse length on timeout", low_total - low0, 3 * TP, 4 * TP + 2);
    got_bits = cap_total - cap0;
    chk("R5 bit count (R2 header dropped)", got_bits, want_bits);
    if (got_bits == want_bits) begin
      int bad = 0;
      for (int k = 0; k < want_bits; k++)
        if (cap[(cap0 + k) % 4096] != exp_bit(k)) bad++;
      chk("R5 bit mismatches", bad, 0);
    end
    chk("R6 low phase length violations", lo_bad, 0);
    chk("R6 data moved with clock high", dat_bad, 0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 prog", tgt_rst_n, 1);
    chk("R1 clk", tgt_clk, 1);
    chk("R1 dat", tgt_dat, 1);
    chk("R1 busy", busy, 0);
    chk("R1 ready", s_ready, 0);
    chk("R1 done_ok", done_ok, 0);
    chk("R1 code", error_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_load(5, 6, 4, 6, 1'b1, 1'b0, 1'b0);    // R2 R5 R6 R7 R9 plain
    do_load(3, 9, 3, 3, 1'b1, 1'b1, 1'b0);    // R2 broken runs in header
    do_load(2, 20, 5, 5, 1'b1, 1'b0, 1'b1);   // R10 restart mid-shift
    do_load(0, 4, 2 * TP, 7, 1'b1, 1'b0, 1'b0); // R3 slow but inside window
    do_load(4, 5, -1, 0, 1'b1, 1'b0, 1'b0);   // R3 clear never falls
    repeat (10) @(negedge clk);
    chk("R8 code held", error_code, 1);
    do_load(4, 5, 3, -1, 1'b1, 1'b0, 1'b0);   // R4 clear never rises
    do_load(1, 7, 3, 3, 1'b0, 1'b0, 1'b0);    // R7 completion missing
    do_load(2, 3, 3, 3, 1'b1, 1'b0, 1'b0);    // R8 cleared by next start
    for (int n = 0; n < 4; n++)
      do_load($urandom_range(0, 6), $urandom_range(1, 16),
              $urandom_range(1, 30), $urandom_range(1, 30), 1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule